// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

A loop over `n` elements cannot always be handed to a vector unit in one pass. The vector registers hold at most `MVL` elements, so the loop has to be cut into strips. This block takes the total count and produces, one strip at a time, the pair (first element index, strip length) that a controller loads into its vector-length register before it runs each pass. The short, odd-sized strip goes first. Every strip after it has the full `MVL` length, so the controller handles the irregular part once and then runs uniform passes to the end.

A one-cycle start pulse captures the total while the block is idle. The strips then come out on a valid/ready port, and a last flag marks the strip that reaches the end of the range. The block does not execute strips and does not touch memory.

When `n` is an exact multiple of `MVL`, the remainder strip would have zero length. Parameter `SUPPRESS_EMPTY` decides what happens to it: at 0 the empty strip is issued as a length-0 pass, and at 1 it is skipped and the sequence opens with a full strip. A total of zero always yields exactly one length-0 strip marked last.

Top module: `strip_seq`

## Requirements
- R1: While reset is held, and after it is released, `strip_valid_o` is low until a start is accepted.
- R2: A start pulse seen while idle captures `total_i`. `strip_valid_o` rises on the next clock edge and the first strip has start index 0.
- R3: The first strip has length `total mod MVL`. The exception is `SUPPRESS_EMPTY`=1 with a nonzero total that is a multiple of `MVL`: the first strip is then `MVL` long.
- R4: Every strip after the first has length `MVL`.
- R5: Each strip's start index equals the previous strip's start index plus the previous strip's length.
- R6: `strip_last_o` is high exactly on the strip whose start plus length equals the captured total. After that strip is accepted, `strip_valid_o` is low on the next cycle.
- R7: The number of strips is `floor(total/MVL)+1`. With `SUPPRESS_EMPTY`=1 and a nonzero total that is a multiple of `MVL`, it is `total/MVL`.
- R8: A total of 0 produces a single strip with start 0, length 0 and the last flag set.
- R9: A start pulse that arrives while a sequence is in progress (`strip_valid_o` high) is ignored. The captured total and the strip sequence carry on unchanged.
- R10: While `strip_valid_o` is high and `strip_ready_i` is low, the start index, length and last flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new sequence; honoured only when idle |
| total_i | input | N_W | Total element count, sampled with an accepted start |
| strip_ready_i | input | 1 | Consumer takes the current strip |
| strip_valid_o | output | 1 | A strip is presented |
| strip_start_o | output | N_W | Index of the strip's first element |
| strip_len_o | output | $clog2(MVL+1) | Strip length, 0 to MVL |
| strip_last_o | output | 1 | This strip reaches the end of the range |

## Verification
The assertions assume that `strip_ready_i` and `start_i` are free inputs that may be asserted in any cycle. They also assume that `MVL` fits in `N_W` bits, so that start plus length never wraps. The stimulus stays inside these limits: totals are drawn below 2^N_W, and ready is toggled at random or held high, including long stalls. Start pulses with unrelated totals are fired at random into running sequences. Two instances run side by side with `SUPPRESS_EMPTY` at 0 and at 1, and they are given the same totals, including zero and exact multiples of `MVL`.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } seq_state_e;

  // Length of the opening strip from the remainder and the suppression choice.
  function automatic int unsigned opening_len(input int unsigned rem,
                                              input bit total_nonzero,
                                              input bit drop_empty,
                                              input int unsigned mvl);
    if (drop_empty && rem == 0 && total_nonzero) return mvl;
    return rem;
  endfunction

  // True when the strip that follows a full step is the closing one.
  function automatic bit closes_after(input int unsigned left_now,
                                      input int unsigned cur_len,
                                      input int unsigned mvl);
    return (left_now - cur_len) == mvl;
  endfunction

endpackage

// File: rtl/strip_first_len.sv
module strip_first_len #(
  parameter int unsigned MVL            = 64,
  parameter int unsigned N_W            = 16,
  parameter bit          SUPPRESS_EMPTY = 1'b0,
  localparam int unsigned LEN_W         = $clog2(MVL + 1)
) (
  input  logic [N_W-1:0]   total_i,
  output logic [LEN_W-1:0] first_len_o
);
  import strip_seq_pkg::*;

  localparam bit IS_POW2 = ((MVL & (MVL - 1)) == 0);

  logic [LEN_W-1:0] rem_w;

  generate
    if (IS_POW2) begin : g_mask
      localparam int unsigned SH = $clog2(MVL);
      assign rem_w = LEN_W'(total_i[SH-1:0]);
    end else begin : g_mod
      assign rem_w = LEN_W'(total_i % N_W'(MVL));
    end
  endgenerate

  always_comb begin
    first_len_o = LEN_W'(opening_len(32'(rem_w), total_i != '0,
                                     SUPPRESS_EMPTY, MVL));
  end
endmodule

// File: rtl/strip_ctrl.sv
module strip_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ready_i,
  input  logic last_i,
  output logic valid_o,
  output logic accept_o,
  output logic advance_o,
  output logic finish_o
);
  import strip_seq_pkg::*;

  seq_state_e state_q, state_d;

  assign valid_o   = (state_q == SEQ_ISSUE);
  assign accept_o  = (state_q == SEQ_IDLE) && start_i;
  assign advance_o = valid_o && ready_i && !last_i;
  assign finish_o  = valid_o && ready_i && last_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (accept_o) state_d = SEQ_ISSUE;
      SEQ_ISSUE: if (finish_o) state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/strip_cursor.sv
module strip_cursor #(
  parameter int unsigned MVL    = 64,
  parameter int unsigned N_W    = 16,
  localparam int unsigned LEN_W = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             advance_i,
  input  logic [N_W-1:0]   total_i,
  input  logic [LEN_W-1:0] first_len_i,
  output logic [N_W-1:0]   start_o,
  output logic [LEN_W-1:0] len_o,
  output logic             last_o,
  output logic [N_W-1:0]   total_o
);
  import strip_seq_pkg::*;

  logic [N_W-1:0]   start_q, left_q, total_q;
  logic [LEN_W-1:0] len_q;
  logic             last_q;
  logic [N_W-1:0]   len_ext;

  assign len_ext = N_W'(len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      left_q  <= '0;
      total_q <= '0;
      len_q   <= '0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      start_q <= '0;
      left_q  <= total_i;
      total_q <= total_i;
      len_q   <= first_len_i;
      last_q  <= (N_W'(first_len_i) == total_i);
    end else if (advance_i) begin
      start_q <= start_q + len_ext;
      left_q  <= left_q - len_ext;
      len_q   <= LEN_W'(MVL);
      last_q  <= closes_after(32'(left_q), 32'(len_q), MVL);
    end
  end

  assign start_o = start_q;
  assign len_o   = len_q;
  assign last_o  = last_q;
  assign total_o = total_q;
endmodule

// File: rtl/strip_seq.sv
module strip_seq #(
  parameter int unsigned MVL            = 64,
  parameter int unsigned N_W            = 16,
  parameter bit          SUPPRESS_EMPTY = 1'b0,
  localparam int unsigned LEN_W         = $clog2(MVL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [N_W-1:0]   total_i,
  input  logic             strip_ready_i,
  output logic             strip_valid_o,
  output logic [N_W-1:0]   strip_start_o,
  output logic [LEN_W-1:0] strip_len_o,
  output logic             strip_last_o
);
  // Named internal events, used by the bound checker.
  logic             accept_w;
  logic             advance_w;
  logic             finish_w;
  logic [N_W-1:0]   total_q_w;
  logic [LEN_W-1:0] first_len_w;

  strip_first_len #(
    .MVL(MVL), .N_W(N_W), .SUPPRESS_EMPTY(SUPPRESS_EMPTY)
  ) u_first (
    .total_i     (total_i),
    .first_len_o (first_len_w)
  );

  strip_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_i   (strip_ready_i),
    .last_i    (strip_last_o),
    .valid_o   (strip_valid_o),
    .accept_o  (accept_w),
    .advance_o (advance_w),
    .finish_o  (finish_w)
  );

  strip_cursor #(.MVL(MVL), .N_W(N_W)) u_cursor (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (accept_w),
    .advance_i   (advance_w),
    .total_i     (total_i),
    .first_len_i (first_len_w),
    .start_o     (strip_start_o),
    .len_o       (strip_len_o),
    .last_o      (strip_last_o),
    .total_o     (total_q_w)
  );
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int unsigned MVL    = 64,
  parameter int unsigned N_W    = 16,
  localparam int unsigned LEN_W = $clog2(MVL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             valid,
  input logic [N_W-1:0]   sidx,
  input logic [LEN_W-1:0] slen,
  input logic             slast,
  input logic             accept,
  input logic             finish,
  input logic [N_W-1:0]   total_q
);
  logic [N_W:0] reach;
  assign reach = {1'b0, sidx} + (N_W+1)'(slen);

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> valid && sidx == '0);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !accept);

  a_r9_total_kept: assert property (@(posedge clk) disable iff (!rst_n)
    valid && $past(valid) |-> $stable(total_q));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !ready |=> valid && $stable(sidx) && $stable(slen) && $stable(slast));

  a_r4_full_len: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !slast |=> valid && slen == LEN_W'(MVL));

  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    valid && ready && !slast |=> {1'b0, sidx} == $past(reach));

  a_r6_drop: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !valid);

  a_r6_last_reach: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (slast == (reach == {1'b0, total_q})));

  a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> reach <= {1'b0, total_q});

  a_r8_zero: assert property (@(posedge clk) disable iff (!rst_n)
    valid && total_q == '0 |-> slast && slen == '0);
endmodule

bind strip_seq strip_seq_chk #(.MVL(MVL), .N_W(N_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ready   (strip_ready_i),
  .valid   (strip_valid_o),
  .sidx    (strip_start_o),
  .slen    (strip_len_o),
  .slast   (strip_last_o),
  .accept  (accept_w),
  .finish  (finish_w),
  .total_q (total_q_w)
);

// File: tb/strip_seq_tb.sv
`timescale 1ns/1ps
module strip_seq_tb;
  localparam int unsigned MVL   = 64;
  localparam int unsigned N_W   = 16;
  localparam int unsigned LEN_W = $clog2(MVL + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N_W-1:0] total = '0;
  logic ready = 1'b0;

  logic [1:0]       vld;
  logic [1:0]       lst;
  logic [N_W-1:0]   st [2];
  logic [LEN_W-1:0] ln [2];

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  strip_seq #(.MVL(MVL), .N_W(N_W), .SUPPRESS_EMPTY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .total_i(total),
    .strip_ready_i(ready), .strip_valid_o(vld[0]), .strip_start_o(st[0]),
    .strip_len_o(ln[0]), .strip_last_o(lst[0])
  );

  strip_seq #(.MVL(MVL), .N_W(N_W), .SUPPRESS_EMPTY(1'b1)) u_dut_sup (
    .clk(clk), .rst_n(rst_n), .start_i(start), .total_i(total),
    .strip_ready_i(ready), .strip_valid_o(vld[1]), .strip_start_o(st[1]),
    .strip_len_o(ln[1]), .strip_last_o(lst[1])
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_first(input int n, input int sup);
    int r = n % MVL;
    if (sup != 0 && r == 0 && n != 0) return MVL;
    return r;
  endfunction

  function automatic int exp_count(input int n, input int sup);
    if (sup != 0 && n != 0 && n % MVL == 0) return n / MVL;
    return n / MVL + 1;
  endfunction

  task automatic run_seq(input int n, input bit rnd_ready, input bit poke);
    int  pos [2];
    int  idx [2];
    bit  done [2];
    int  elen [2];
    bit  elast [2];
    bit  stalled [2];
    bit  rdy;
    int  cyc = 0;
    @(negedge clk);
    start = 1'b1; total = N_W'(n); ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int d = 0; d < 2; d++) begin
      pos[d] = 0; idx[d] = 0; done[d] = 1'b0; stalled[d] = 1'b0;
      check(vld[d] == 1'b1, "R2 valid after start", int'(vld[d]), 1);
    end
    while (!(done[0] && done[1])) begin
      for (int d = 0; d < 2; d++) begin
        if (!done[d]) begin
          elen[d]  = (idx[d] == 0) ? exp_first(n, d) : MVL;
          elast[d] = (pos[d] + elen[d] == n);
          check(vld[d] == 1'b1, "R7 strip present", int'(vld[d]), 1);
          check(int'(st[d]) == pos[d], stalled[d] ? "R10 start held" :
                (idx[d] == 0 ? "R2 first start" : "R5 start index"),
                int'(st[d]), pos[d]);
          check(int'(ln[d]) == elen[d], (n == 0) ? "R8 zero length" :
                (idx[d] == 0 ? "R3 first length" : "R4 full length"),
                int'(ln[d]), elen[d]);
          check(lst[d] == elast[d], (n == 0) ? "R8 zero last" : "R6 last flag",
                int'(lst[d]), int'(elast[d]));
        end
      end
      rdy   = rnd_ready ? ($urandom % 4 != 0) : 1'b1;
      ready = rdy;
      start = poke && (vld == 2'b11) && ($urandom % 3 == 0);
      total = N_W'($urandom);
      @(posedge clk);
      for (int d = 0; d < 2; d++) begin
        stalled[d] = !rdy;
        if (!done[d] && rdy) begin
          if (elast[d]) done[d] = 1'b1;
          pos[d] += elen[d];
          idx[d]++;
        end
      end
      @(negedge clk);
      start = 1'b0; ready = 1'b0;
      for (int d = 0; d < 2; d++) begin
        if (done[d] && rdy && elast[d] && idx[d] > 0 && pos[d] == n) begin
          check(vld[d] == 1'b0, "R6 valid drops", int'(vld[d]), 0);
          check(idx[d] == exp_count(n, d), "R7 strip count", idx[d], exp_count(n, d));
          elast[d] = 1'b0;
        end
      end
      cyc++;
      if (cyc > 20000) begin
        check(1'b0, "R7 sequence ends", cyc, 0);
        done[0] = 1'b1; done[1] = 1'b1;
      end
      if (!done[0] || !done[1]) begin
        // loop resumes at this negedge with fresh outputs
      end
    end
    // return to idle state on the ports; the sequence is over
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(vld == 2'b00, "R1 idle in reset", int'(vld), 0);
    start = 1'b1; total = 16'd10;
    @(negedge clk);
    check(vld == 2'b00, "R1 start ignored in reset", int'(vld), 0);
    start = 1'b0;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(vld == 2'b00, "R1 idle after reset", int'(vld), 0);

    // directed corner cases
    run_seq(0,    1'b0, 1'b0);  // R8
    run_seq(1,    1'b0, 1'b0);
    run_seq(63,   1'b0, 1'b0);
    run_seq(64,   1'b0, 1'b0);  // R3 / R7 exact multiple
    run_seq(65,   1'b1, 1'b0);
    run_seq(128,  1'b1, 1'b1);  // R9 pokes while busy
    run_seq(200,  1'b1, 1'b1);
    run_seq(4096, 1'b0, 1'b1);
    run_seq(65535, 1'b0, 1'b0);

    // constrained random totals, random ready and stray starts
    for (int i = 0; i < 60; i++) begin
      int n;
      case ($urandom % 4)
        0:       n = ($urandom % 10) * MVL;
        1:       n = $urandom % MVL;
        default: n = $urandom % 700;
      endcase
      run_seq(n, 1'b1, 1'b1);
    end

    repeat (3) @(negedge clk);
    check(vld == 2'b00, "R9 no stray sequence", int'(vld), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule